// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry half of exception handling for a simple 32-bit RISC core. A one-cycle strobe from the pipeline carries an exception code, the current program counter and a flag that tells whether the faulting instruction sat in a branch delay slot. In the next cycle the block has done several things. It has stored an adjusted return address, the faulting address for illegal instructions, and a copy of the status word as it was before entry. It has rewritten the status word into a safe supervisor state. It has cleared the power-management request bits and invalidated the load-link reservation. It has also issued a one-cycle redirect carrying the handler vector.

The block also chooses between an external device interrupt and a tick-timer interrupt. Each one is gated by its own enable bit in the status word. An accepted interrupt goes through the same entry path as a synchronous exception. The block owns the status, power-management and reservation registers. The core can still write them through plain write ports when no entry is taking place. A code that names no handler produces a fatal pulse and changes no state.

Top module: `exc_entry_ctl`

## Requirements
- R1: After synchronous reset the status word is 0x0001 (supervisor only). The saved-PC, saved-status and error-address registers are zero, the power-management bits are zero, the reservation is all ones, and the redirect, fatal and delay-clear outputs are low.
- R2: On an accepted entry the saved PC is the current PC. For code 12 (system call) it is the current PC plus 4.
- R3: When the delay-slot input is high at entry, the saved PC is reduced by 4 from its R2 value, status bit 6 (delay-slot exception) is set, and `dslot_clr` pulses. Otherwise bit 6 is cleared.
- R4: The error-address register takes the current PC only for code 7 (illegal instruction). Every other entry leaves it unchanged.
- R5: The saved-status register receives the status word as it was before the entry changed it.
- R6: At entry the status word clears bits 1 (tick enable), 2 (interrupt enable), 3 (data translation) and 4 (instruction translation), and sets bit 0 (supervisor). Bit 5 and all other bits are kept.
- R7: At entry the power-management bits (bit 0 doze, bit 1 sleep) clear and the reservation becomes all ones.
- R8: The redirect PC is the code shifted left by 8. It is OR-ed with `vec_base` when `vbase_en` is high, and with 0xF0000000 when status bit 5 (high vector page) was set before entry.
- R9: An external interrupt is accepted only while status bit 2 is set. It enters with code 8.
- R10: A tick interrupt is accepted only while status bit 1 is set. It enters with code 5. When both are pending and enabled, the tick interrupt is taken.
- R11: A synchronous exception strobe takes priority over any pending enabled interrupt in the same cycle.
- R12: A strobed code of 0 or 15 or above raises `fatal` for one cycle. No redirect is issued and no register changes.
- R13: All results of an entry appear in the cycle after the strobe, and the redirect and fatal outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_exc | input | 1 | One-cycle exception strobe |
| exc_code | input | 4 | Exception code with the strobe |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_dslot | input | 1 | Instruction was in a branch delay slot |
| irq_ext | input | 1 | External device interrupt request |
| irq_tick | input | 1 | Tick-timer interrupt request |
| sr_wr_en | input | 1 | Status word write enable |
| sr_wr_data | input | 16 | Status word write value |
| pm_wr_en | input | 1 | Power-management write enable |
| pm_wr_data | input | 2 | Power-management write value |
| resv_set | input | 1 | Load-link reservation set |
| resv_addr_in | input | 32 | Reservation address to set |
| vbase_en | input | 1 | Configuration bit enabling the vector base |
| vec_base | input | 32 | Programmable vector base |
| sr_q | output | 16 | Status word |
| esr_q | output | 16 | Saved status word |
| epc_q | output | 32 | Saved return PC |
| eear_q | output | 32 | Error effective address |
| pm_q | output | 2 | Power-management bits |
| resv_q | output | 32 | Load-link reservation address |
| redir_vld | output | 1 | Redirect valid pulse |
| redir_pc | output | 32 | Handler vector |
| dslot_clr | output | 1 | Pulse that clears the core's delay flag |
| fatal | output | 1 | Unhandled code pulse |

## Verification
Each entry goes through exactly one register stage. The saved registers, the status word, the redirect and the fatal pulse are therefore all due at the first rising edge after the strobe. The bench drives every stimulus on a falling edge and samples one falling edge later, which falls between that edge and the next one. It samples once more a cycle later to confirm that the pulses have dropped. Interrupt requests are held for exactly one cycle, so each accepted request leads to a single entry that the bench can check at that same point.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // status word bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 3;
  localparam int SR_IME = 4;
  localparam int SR_EPH = 5;
  localparam int SR_DSX = 6;
  // exception codes with special handling
  localparam int EC_TICK    = 5;
  localparam int EC_ILLEGAL = 7;
  localparam int EC_EXT     = 8;
  localparam int EC_SYSCALL = 12;
endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              take_exc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_ext,
  input  logic              irq_tick,
  input  logic              ie_en,
  input  logic              te_en,
  output logic              go,
  output logic [CODE_W-1:0] code
);
  logic tick_ok, ext_ok;

  always_comb begin
    tick_ok = irq_tick & te_en;
    ext_ok  = irq_ext & ie_en;
    go      = take_exc | tick_ok | ext_ok;
    if (take_exc)     code = exc_code;
    else if (tick_ok) code = CODE_W'(EC_TICK);
    else              code = CODE_W'(EC_EXT);
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 15,
  parameter int VEC_SHIFT = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic              vbase_en,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              hi_page,
  output logic [XLEN-1:0]   vec,
  output logic              code_ok
);
  localparam logic [XLEN-1:0] HI_PREFIX = {4'hF, {(XLEN-4){1'b0}}};

  logic [XLEN-1:0] raw;

  always_comb begin
    raw     = XLEN'(code) << VEC_SHIFT;
    vec     = raw | (vbase_en ? vec_base : '0) | (hi_page ? HI_PREFIX : '0);
    code_ok = (code != '0) && (32'(code) < 32'(NUM_CODES));
  end
endmodule

// File: rtl/exc_epc_adj.sv
module exc_epc_adj
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [CODE_W-1:0] code,
  input  logic              in_dslot,
  output logic [XLEN-1:0]   epc_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] plus;

  always_comb begin
    plus     = (code == CODE_W'(EC_SYSCALL)) ? cur_pc + STEP : cur_pc;
    epc_next = in_dslot ? plus - STEP : plus;
  end
endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 15,
  parameter int SR_W      = 16,
  parameter int VEC_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_exc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_dslot,
  input  logic              irq_ext,
  input  logic              irq_tick,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  input  logic              pm_wr_en,
  input  logic [1:0]        pm_wr_data,
  input  logic              resv_set,
  input  logic [XLEN-1:0]   resv_addr_in,
  input  logic              vbase_en,
  input  logic [XLEN-1:0]   vec_base,
  output logic [SR_W-1:0]   sr_q,
  output logic [SR_W-1:0]   esr_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   eear_q,
  output logic [1:0]        pm_q,
  output logic [XLEN-1:0]   resv_q,
  output logic              redir_vld,
  output logic [XLEN-1:0]   redir_pc,
  output logic              dslot_clr,
  output logic              fatal
);
  localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << SR_SM;

  logic              go, code_ok, accept, bad;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   vec, epc_next;
  logic [SR_W-1:0]   sr_entry;

  exc_irq_arb #(.CODE_W(CODE_W)) u_arb (
    .take_exc (take_exc),
    .exc_code (exc_code),
    .irq_ext  (irq_ext),
    .irq_tick (irq_tick),
    .ie_en    (sr_q[SR_IEE]),
    .te_en    (sr_q[SR_TEE]),
    .go       (go),
    .code     (code)
  );

  exc_vec_gen #(
    .XLEN(XLEN), .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .VEC_SHIFT(VEC_SHIFT)
  ) u_vec (
    .code     (code),
    .vbase_en (vbase_en),
    .vec_base (vec_base),
    .hi_page  (sr_q[SR_EPH]),
    .vec      (vec),
    .code_ok  (code_ok)
  );

  exc_epc_adj #(.XLEN(XLEN), .CODE_W(CODE_W)) u_epc (
    .cur_pc   (cur_pc),
    .code     (code),
    .in_dslot (in_dslot),
    .epc_next (epc_next)
  );

  always_comb begin
    accept   = go & code_ok;
    bad      = go & ~code_ok;
    sr_entry = sr_q;
    sr_entry[SR_DME] = 1'b0;
    sr_entry[SR_IME] = 1'b0;
    sr_entry[SR_IEE] = 1'b0;
    sr_entry[SR_TEE] = 1'b0;
    sr_entry[SR_SM]  = 1'b1;
    sr_entry[SR_DSX] = in_dslot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= SR_RESET;
      esr_q     <= '0;
      epc_q     <= '0;
      eear_q    <= '0;
      pm_q      <= '0;
      resv_q    <= '1;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
      dslot_clr <= 1'b0;
      fatal     <= 1'b0;
    end else begin
      redir_vld <= accept;
      fatal     <= bad;
      dslot_clr <= accept & in_dslot;
      if (accept) begin
        redir_pc <= vec;
        epc_q    <= epc_next;
        esr_q    <= sr_q;
        sr_q     <= sr_entry;
        pm_q     <= '0;
        resv_q   <= '1;
        if (code == CODE_W'(EC_ILLEGAL)) eear_q <= cur_pc;
      end else begin
        if (sr_wr_en) sr_q   <= sr_wr_data;
        if (pm_wr_en) pm_q   <= pm_wr_data;
        if (resv_set) resv_q <= resv_addr_in;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 15,
  parameter int SR_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              take_exc,
  input logic [CODE_W-1:0] exc_code,
  input logic              in_dslot,
  input logic [SR_W-1:0]   sr_q,
  input logic [SR_W-1:0]   esr_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [1:0]        pm_q,
  input logic [XLEN-1:0]   resv_q,
  input logic              redir_vld,
  input logic              dslot_clr,
  input logic              fatal
);
  a_r6_sr_entry: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> (sr_q[SR_SM] && !sr_q[SR_IEE] && !sr_q[SR_TEE] && !sr_q[SR_DME] && !sr_q[SR_IME]));

  a_r5_esr_pre: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> (esr_q == $past(sr_q)));

  a_r7_resv_pm: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> ((&resv_q) && (pm_q == 2'b00)));

  a_r12_fatal_quiet: assert property (@(posedge clk) disable iff (rst)
    fatal |-> (!redir_vld && $stable(epc_q) && $stable(esr_q) && $stable(sr_q)));

  a_r12_fatal_src: assert property (@(posedge clk) disable iff (rst)
    fatal |-> ($past(take_exc) && ($past(exc_code) == '0 || 32'($past(exc_code)) >= 32'(NUM_CODES))));

  a_r3_dsx_flag: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> (sr_q[SR_DSX] == dslot_clr));

  a_r3_dslot_src: assert property (@(posedge clk) disable iff (rst)
    dslot_clr |-> $past(in_dslot));
endmodule

bind exc_entry_ctl exc_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .SR_W(SR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .take_exc  (take_exc),
  .exc_code  (exc_code),
  .in_dslot  (in_dslot),
  .sr_q      (sr_q),
  .esr_q     (esr_q),
  .epc_q     (epc_q),
  .pm_q      (pm_q),
  .resv_q    (resv_q),
  .redir_vld (redir_vld),
  .dslot_clr (dslot_clr),
  .fatal     (fatal)
);

// File: tb/sim_exc_entry_ctl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctl;
  localparam int B_SM = 0, B_TEE = 1, B_IEE = 2, B_DME = 3, B_IME = 4, B_EPH = 5, B_DSX = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_exc = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] cur_pc = '0;
  logic        in_dslot = 1'b0;
  logic        irq_ext = 1'b0, irq_tick = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [15:0] sr_wr_data = '0;
  logic        pm_wr_en = 1'b0;
  logic [1:0]  pm_wr_data = '0;
  logic        resv_set = 1'b0;
  logic [31:0] resv_addr_in = '0;
  logic        vbase_en = 1'b0;
  logic [31:0] vec_base = '0;
  logic [15:0] sr_q, esr_q;
  logic [31:0] epc_q, eear_q, resv_q, redir_pc;
  logic [1:0]  pm_q;
  logic        redir_vld, dslot_clr, fatal;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  exc_entry_ctl u0 (
    .clk(clk), .rst(rst), .take_exc(take_exc), .exc_code(exc_code), .cur_pc(cur_pc),
    .in_dslot(in_dslot), .irq_ext(irq_ext), .irq_tick(irq_tick),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .pm_wr_en(pm_wr_en), .pm_wr_data(pm_wr_data),
    .resv_set(resv_set), .resv_addr_in(resv_addr_in), .vbase_en(vbase_en), .vec_base(vec_base),
    .sr_q(sr_q), .esr_q(esr_q), .epc_q(epc_q), .eear_q(eear_q), .pm_q(pm_q), .resv_q(resv_q),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .dslot_clr(dslot_clr), .fatal(fatal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // preload status, power bits and reservation through the write ports
  task automatic preload(input logic [15:0] s, input logic [31:0] rv);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_data = s;
    pm_wr_en = 1'b1; pm_wr_data = 2'b11;
    resv_set = 1'b1; resv_addr_in = rv;
    @(negedge clk);
    sr_wr_en = 1'b0; pm_wr_en = 1'b0; resv_set = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 sr", 32'(sr_q), 32'h1);
    chk("R1 epc", epc_q, 0);
    chk("R1 esr", 32'(esr_q), 0);
    chk("R1 eear", eear_q, 0);
    chk("R1 pm", 32'(pm_q), 0);
    chk("R1 resv", resv_q, 32'hFFFF_FFFF);
    chk("R1 pulses", {29'b0, redir_vld, fatal, dslot_clr}, 0);

    // sweep: every code x delay slot x base enable x high page
    for (int c = 0; c < 16; c++) begin
      for (int d = 0; d < 2; d++) begin
        for (int v = 0; v < 2; v++) begin
          for (int e = 0; e < 2; e++) begin
            logic [15:0] spre, sexp;
            logic [31:0] pc, base, rv, exp_pc, exp_vec, prev_epc, prev_eear;
            logic [15:0] prev_esr;
            bit ok;
            spre = 16'h0200 | (16'(1) << B_TEE) | (16'(1) << B_IEE) | (16'(1) << B_DME)
                 | (16'(1) << B_IME) | (16'(e) << B_EPH) | (16'(d ^ 1) << B_DSX);
            pc   = 32'h1000_0000 + 32'(c) * 32'h40 + 32'(d) * 32'h8 + 32'(v) * 32'h4000;
            base = 32'h0012_3000;
            rv   = pc ^ 32'h5555_0000;
            preload(spre, rv);
            prev_epc = epc_q; prev_eear = eear_q; prev_esr = esr_q;
            take_exc = 1'b1; exc_code = 4'(c); cur_pc = pc; in_dslot = d[0];
            vbase_en = v[0]; vec_base = base;
            @(negedge clk);
            take_exc = 1'b0; in_dslot = 1'b0;
            ok = (c >= 1) && (c <= 14);
            if (ok) begin
              exp_pc = pc + ((c == 12) ? 32'd4 : 32'd0) - (d ? 32'd4 : 32'd0);
              exp_vec = (32'(c) << 8) | (v ? base : 32'h0) | (e ? 32'hF000_0000 : 32'h0);
              sexp = (spre & ~((16'(1) << B_TEE) | (16'(1) << B_IEE) | (16'(1) << B_DME)
                     | (16'(1) << B_IME) | (16'(1) << B_DSX))) | (16'(1) << B_SM) | (16'(d) << B_DSX);
              chk("R13 redirect valid", 32'(redir_vld), 1);
              chk("R12 no fatal on valid code", 32'(fatal), 0);
              chk("R8 vector", redir_pc, exp_vec);
              chk("R2 saved pc", epc_q, exp_pc);
              chk("R3 delay clear pulse", 32'(dslot_clr), 32'(d));
              chk("R4 error address", eear_q, (c == 7) ? pc : prev_eear);
              chk("R5 saved status", 32'(esr_q), 32'(spre));
              chk("R6 status rewrite", 32'(sr_q), 32'(sexp));
              chk("R7 power bits", 32'(pm_q), 0);
              chk("R7 reservation", resv_q, 32'hFFFF_FFFF);
            end else begin
              chk("R12 fatal", 32'(fatal), 1);
              chk("R12 no redirect", 32'(redir_vld), 0);
              chk("R12 epc kept", epc_q, prev_epc);
              chk("R12 esr kept", 32'(esr_q), 32'(prev_esr));
              chk("R12 eear kept", eear_q, prev_eear);
              chk("R12 sr kept", 32'(sr_q), 32'(spre));
              chk("R12 pm kept", 32'(pm_q), 3);
              chk("R12 resv kept", resv_q, rv);
            end
            @(negedge clk);
            chk("R13 pulses drop", {29'b0, redir_vld, fatal, dslot_clr}, 0);
          end
        end
      end
    end

    // interrupt gating and priority, all 16 combinations
    vbase_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      bit ie, te, xe, tk, exp_go;
      logic [31:0] exp_code;
      ie = k[0]; te = k[1]; xe = k[2]; tk = k[3];
      preload((16'(ie) << B_IEE) | (16'(te) << B_TEE), 32'h0);
      irq_ext = xe; irq_tick = tk; cur_pc = 32'h2000_0000 + 32'(k) * 4;
      @(negedge clk);
      irq_ext = 1'b0; irq_tick = 1'b0;
      exp_go = (tk && te) || (xe && ie);
      exp_code = (tk && te) ? 32'd5 : 32'd8;
      chk(xe ? "R9 ext gating" : "R10 tick gating", 32'(redir_vld), 32'(exp_go));
      if (exp_go) begin
        chk("R10 tick wins / R9 ext vector", redir_pc, exp_code << 8);
        chk("R2 irq saved pc", epc_q, 32'h2000_0000 + 32'(k) * 4);
      end
      @(negedge clk);
    end

    // R11 strobe beats enabled pending interrupts
    preload((16'(1) << B_IEE) | (16'(1) << B_TEE), 32'h0);
    irq_ext = 1'b1; irq_tick = 1'b1; take_exc = 1'b1; exc_code = 4'd2; cur_pc = 32'h3000_0010;
    @(negedge clk);
    irq_ext = 1'b0; irq_tick = 1'b0; take_exc = 1'b0;
    chk("R11 strobe priority vector", redir_pc, 32'h200);
    chk("R11 strobe priority valid", 32'(redir_vld), 1);

    // R11/R12 bad strobe code with enabled tick pending: fatal, no entry
    preload((16'(1) << B_TEE), 32'h0);
    irq_tick = 1'b1; take_exc = 1'b1; exc_code = 4'd0;
    @(negedge clk);
    irq_tick = 1'b0; take_exc = 1'b0;
    chk("R11 bad strobe still wins", 32'(fatal), 1);
    chk("R12 no redirect with tick pending", 32'(redir_vld), 0);
    chk("R12 sr unchanged", 32'(sr_q), 32'(16'(1) << B_TEE));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule